// File: doc/BRIEF.md
# Half-Rate to Double-Data-Rate Output Serializer

This block sits between core logic that runs at half the interface rate and the pad driver of a source-synchronous memory or link interface. In each half-rate cycle the core hands over four write bits per lane and two output-enable bits. A first stage turns that wide word into a single-rate stream of bit pairs on the full-rate clock. A second stage sends each pair on the two halves of a full-rate cycle: the even bit while the clock is high and the odd bit while it is low. A matching enable pipeline drives the tristate control and keeps it aligned with the data.

The half-rate clock is modelled as a strobe, `hr_tick`. It runs on the full-rate clock and is high in every other cycle. Core logic presents a new word in any cycle where the strobe is high. Two static configuration inputs change the pipeline. The first removes the half-rate stage, so the core then supplies one bit pair and one enable bit every full-rate cycle. The second switches the output stage between double-rate, registered single-rate and combinational single-rate operation. The fixed latency of each setting is published as package constants.

Top module: `hrddr_serializer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `dq_rise`, `dq_fall`, `oe_rise` and `oe_fall` are 0 (inputs held at 0) and `hr_tick` is 1.
- R2: After reset `hr_tick` is 1 in the first cycle and then alternates every full-rate cycle.
- R3: With the half-rate stage active, the word on `core_wdata`/`core_oe` is taken only in a cycle where `hr_tick` is 1. Input values in the other cycles have no effect on any output.
- R4: Lane l uses `core_wdata[4l+3:4l]`. Bits 4l and 4l+1 form the first full-rate slot and bits 4l+2 and 4l+3 the second. `core_oe[0]` covers the first slot and `core_oe[1]` the second. In double-rate mode (`cfg_out_mode` = 0) the even bit of a slot appears on `dq_rise` and the odd bit on `dq_fall`.
- R5: The first slot of a word taken in cycle t appears in cycle t + H + G, and the second slot one cycle later. H is 1 with the half-rate stage active and 0 when it is bypassed. G is 1 for modes 0 and 1 and 0 for modes 2 and 3.
- R6: With `cfg_hr_bypass` = 1, bits 4l and 4l+1 of each lane and `core_oe[0]` are taken every full-rate cycle. Bits 4l+2, 4l+3 and `core_oe[1]` are ignored.
- R7: In registered single-rate mode (`cfg_out_mode` = 1) the even bit of each slot is driven on both `dq_rise` and `dq_fall`, and the odd bit is ignored.
- R8: In combinational single-rate mode (`cfg_out_mode` = 2, and code 3 acts the same) the even bit of each slot is driven on both halves with no output register.
- R9: In double-rate mode `oe_fall` equals the enable bit of the current slot. `oe_rise` equals the OR of that bit and the enable bit of the previous slot, so the drive stays on for one extra half cycle after the last enabled slot.
- R10: In both single-rate modes `oe_rise` and `oe_fall` both equal the enable bit of the current slot, with no extension.
- R11: `dq_pin` and `oe_pin` carry the rise-half values while `clk` is high and the fall-half values while `clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hr_bypass | input | 1 | Static: 1 removes the half-rate stage |
| cfg_out_mode | input | 2 | Static: 0 double-rate, 1 registered single-rate, 2 or 3 combinational single-rate |
| core_wdata | input | 4*LANES | Four write bits per lane from the core |
| core_oe | input | 2 | Output-enable bits for the two slots |
| hr_tick | output | 1 | Half-rate strobe: the word is taken in this cycle |
| dq_rise | output | LANES | Bit sent while the clock is high |
| dq_fall | output | LANES | Bit sent while the clock is low |
| dq_pin | output | LANES | Pin-level data stream, muxed by clk |
| oe_rise | output | 1 | Drive enable for the high half |
| oe_fall | output | 1 | Drive enable for the low half |
| oe_pin | output | 1 | Pin-level tristate control, muxed by clk |

## Verification
Two events share a cycle on every strobe cycle. The half-rate stage loads a new word while the second slot of the previous word is still leaving it. In the same cycle the enable extension from the previous slot overlaps the enable of the current slot. The bench runs back-to-back words with random enable patterns. Isolated enable pulses, runs of enables and new loads all fall on those shared cycles. Each cycle the outputs are compared with a reference table built from the requirements. Between strobes the bench drives garbage, and any leak of it, or a lost second slot, shows up as a mismatch at the expected cycle.

// File: rtl/hrddr_pkg.sv
package hrddr_pkg;

    typedef enum logic [1:0] {
        MODE_DDR      = 2'd0,
        MODE_SDR_REG  = 2'd1,
        MODE_SDR_COMB = 2'd2,
        MODE_SDR_ALT  = 2'd3
    } out_mode_e;

    // Cycles from the cycle a word is taken to the cycle its first slot is driven
    localparam int unsigned LAT_HR_DDR      = 2;
    localparam int unsigned LAT_HR_SDR_REG  = 2;
    localparam int unsigned LAT_HR_SDR_COMB = 1;
    localparam int unsigned LAT_BY_DDR      = 1;
    localparam int unsigned LAT_BY_SDR_REG  = 1;
    localparam int unsigned LAT_BY_SDR_COMB = 0;

    function automatic logic mode_is_registered(out_mode_e m);
        return (m == MODE_DDR) || (m == MODE_SDR_REG);
    endfunction

    function automatic int unsigned path_latency(logic hr_bypass, out_mode_e m);
        if (hr_bypass)
            return mode_is_registered(m) ? LAT_BY_DDR : LAT_BY_SDR_COMB;
        return mode_is_registered(m) ? LAT_HR_DDR : LAT_HR_SDR_COMB;
    endfunction

endpackage

// File: rtl/hrddr_tick_gen.sv
module hrddr_tick_gen (
    input  logic clk,
    input  logic rst,
    output logic hr_tick
);
    typedef struct packed {
        logic phase;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hr_tick = ~st_q.phase;

    // R2
    tick_fall_chk: assert property (@(posedge clk) disable iff (rst)
        hr_tick |=> !hr_tick);
    // R2
    tick_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !hr_tick |=> hr_tick);

endmodule

// File: rtl/hrddr_hr2sdr.sv
module hrddr_hr2sdr #(
    parameter int unsigned SLOT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hr_tick,
    input  logic                bypass,
    input  logic [2*SLOT_W-1:0] word_in,
    output logic [SLOT_W-1:0]   slot_out
);
    localparam int unsigned WORD_W = 2 * SLOT_W;

    typedef struct packed {
        logic [WORD_W-1:0] hold;
    } hr_st_t;

    hr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hr_tick) st_d.hold = word_in;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // The cycle after a load carries the low slot; the next strobe cycle the high slot
    always_comb begin
        if (bypass)       slot_out = word_in[SLOT_W-1:0];
        else if (hr_tick) slot_out = st_q.hold[WORD_W-1:SLOT_W];
        else              slot_out = st_q.hold[SLOT_W-1:0];
    end

    // R3
    low_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (!bypass && $past(hr_tick) && !$past(rst))
        |-> slot_out == $past(word_in[SLOT_W-1:0]));
    // R4
    high_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (!bypass && hr_tick && !$past(rst) && !$past(rst, 2))
        |-> slot_out == $past(word_in[WORD_W-1:SLOT_W], 2));

endmodule

// File: rtl/hrddr_ddr_data.sv
module hrddr_ddr_data
    import hrddr_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  out_mode_e    mode,
    input  logic [W-1:0] even_in,
    input  logic [W-1:0] odd_in,
    output logic [W-1:0] rise_out,
    output logic [W-1:0] fall_out
);
    typedef struct packed {
        logic [W-1:0] reg_a;
        logic [W-1:0] reg_b;
    } dd_st_t;

    dd_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.reg_a = even_in;
        st_d.reg_b = odd_in;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        unique case (mode)
            MODE_DDR: begin
                rise_out = st_q.reg_a;
                fall_out = st_q.reg_b;
            end
            MODE_SDR_REG: begin
                rise_out = st_q.reg_a;
                fall_out = st_q.reg_a;
            end
            default: begin
                rise_out = even_in;
                fall_out = even_in;
            end
        endcase
    end

    // R4
    ddr_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DDR && !$past(rst))
        |-> (rise_out == $past(even_in)) && (fall_out == $past(odd_in)));
    // R7
    sdr_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SDR_REG && !$past(rst))
        |-> (rise_out == $past(even_in)) && (fall_out == $past(even_in)));

endmodule

// File: rtl/hrddr_ddr_oe.sv
module hrddr_ddr_oe
    import hrddr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  out_mode_e mode,
    input  logic      oe_in,
    output logic      oe_rise,
    output logic      oe_fall
);
    typedef struct packed {
        logic oe_a;
        logic oe_b;
    } oe_st_t;

    oe_st_t st_d, st_q;

    // Register B trails register A by one slot; ORing them stretches the drive
    always_comb begin
        st_d      = st_q;
        st_d.oe_a = oe_in;
        st_d.oe_b = st_q.oe_a;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        unique case (mode)
            MODE_DDR: begin
                oe_rise = st_q.oe_a | st_q.oe_b;
                oe_fall = st_q.oe_a;
            end
            MODE_SDR_REG: begin
                oe_rise = st_q.oe_a;
                oe_fall = st_q.oe_a;
            end
            default: begin
                oe_rise = oe_in;
                oe_fall = oe_in;
            end
        endcase
    end

    // R9
    oe_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DDR && !$past(rst) && !$past(rst, 2))
        |-> (oe_rise == ($past(oe_in) | $past(oe_in, 2))) && (oe_fall == $past(oe_in)));
    // R10
    oe_sdr_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SDR_REG && !$past(rst))
        |-> (oe_rise == $past(oe_in)) && (oe_fall == $past(oe_in)));

endmodule

// File: rtl/hrddr_serializer.sv
module hrddr_serializer
    import hrddr_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_hr_bypass,
    input  logic [1:0]         cfg_out_mode,
    input  logic [4*LANES-1:0] core_wdata,
    input  logic [1:0]         core_oe,
    output logic               hr_tick,
    output logic [LANES-1:0]   dq_rise,
    output logic [LANES-1:0]   dq_fall,
    output logic [LANES-1:0]   dq_pin,
    output logic               oe_rise,
    output logic               oe_fall,
    output logic               oe_pin
);
    localparam int unsigned SLOT_W = 2 * LANES;

    out_mode_e              mode;
    logic [2*SLOT_W-1:0]    data_word;
    logic [SLOT_W-1:0]      data_slot;
    logic                   oe_slot;

    assign mode = out_mode_e'(cfg_out_mode);

    // Slot layout: [LANES-1:0] even bits, [2*LANES-1:LANES] odd bits
    for (genvar l = 0; l < LANES; l++) begin : g_lane_map
        assign data_word[l]                   = core_wdata[4*l];
        assign data_word[LANES + l]           = core_wdata[4*l + 1];
        assign data_word[SLOT_W + l]          = core_wdata[4*l + 2];
        assign data_word[SLOT_W + LANES + l]  = core_wdata[4*l + 3];
    end

    hrddr_tick_gen u_tick (
        .clk     (clk),
        .rst     (rst),
        .hr_tick (hr_tick)
    );

    hrddr_hr2sdr #(.SLOT_W(SLOT_W)) u_data_hr (
        .clk      (clk),
        .rst      (rst),
        .hr_tick  (hr_tick),
        .bypass   (cfg_hr_bypass),
        .word_in  (data_word),
        .slot_out (data_slot)
    );

    hrddr_hr2sdr #(.SLOT_W(1)) u_oe_hr (
        .clk      (clk),
        .rst      (rst),
        .hr_tick  (hr_tick),
        .bypass   (cfg_hr_bypass),
        .word_in  (core_oe),
        .slot_out (oe_slot)
    );

    hrddr_ddr_data #(.W(LANES)) u_data_ddr (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .even_in  (data_slot[LANES-1:0]),
        .odd_in   (data_slot[SLOT_W-1:LANES]),
        .rise_out (dq_rise),
        .fall_out (dq_fall)
    );

    hrddr_ddr_oe u_oe_ddr (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .oe_in   (oe_slot),
        .oe_rise (oe_rise),
        .oe_fall (oe_fall)
    );

    // Pin-level mux: the high clock phase carries the rise-half values
    always_comb begin
        dq_pin = clk ? dq_rise : dq_fall;
        oe_pin = clk ? oe_rise : oe_fall;
    end

    // R8
    sdr_comb_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_is_registered(mode) && cfg_hr_bypass)
        |-> (dq_rise == core_wdata_even0()) && (dq_fall == dq_rise));

    function automatic logic [LANES-1:0] core_wdata_even0();
        logic [LANES-1:0] v;
        for (int l = 0; l < LANES; l++) v[l] = core_wdata[4*l];
        return v;
    endfunction

endmodule

// File: tb/tb_hrddr_serializer.sv
`timescale 1ns/1ps
module tb_hrddr_serializer;
    import hrddr_pkg::*;

    localparam int LANES = 4;
    localparam int NCYC  = 120;
    localparam int DEPTH = 512;

    logic               clk = 1'b0;
    logic               rst;
    logic               cfg_hr_bypass;
    logic [1:0]         cfg_out_mode;
    logic [4*LANES-1:0] core_wdata;
    logic [1:0]         core_oe;
    logic               hr_tick;
    logic [LANES-1:0]   dq_rise, dq_fall, dq_pin;
    logic               oe_rise, oe_fall, oe_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [LANES-1:0] exp_even [DEPTH];
    logic [LANES-1:0] exp_odd  [DEPTH];
    logic             exp_oe   [DEPTH];

    always #2.5 clk = ~clk;

    hrddr_serializer #(.LANES(LANES)) dut (
        .clk           (clk),
        .rst           (rst),
        .cfg_hr_bypass (cfg_hr_bypass),
        .cfg_out_mode  (cfg_out_mode),
        .core_wdata    (core_wdata),
        .core_oe       (core_oe),
        .hr_tick       (hr_tick),
        .dq_rise       (dq_rise),
        .dq_fall       (dq_fall),
        .dq_pin        (dq_pin),
        .oe_rise       (oe_rise),
        .oe_fall       (oe_fall),
        .oe_pin        (oe_pin)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int cyc, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s cycle %0d actual %h expected %h", req, what, cyc, act, expv);
        end
    endtask

    function automatic bit is_reg(input logic [1:0] m);
        return (m == 2'd0) || (m == 2'd1);
    endfunction

    task automatic clear_expect();
        for (int i = 0; i < DEPTH; i++) begin
            exp_even[i] = '0;
            exp_odd[i]  = '0;
            exp_oe[i]   = 1'b0;
        end
    endtask

    task automatic record(input int idx, input int k);
        for (int l = 0; l < LANES; l++) begin
            exp_even[idx][l] = core_wdata[4*l + 2*k];
            exp_odd[idx][l]  = core_wdata[4*l + 2*k + 1];
        end
        exp_oe[idx] = core_oe[k];
    endtask

    // Applies config and reset, checks the reset state (R1), leaves time at the release negedge
    task automatic start_mode(input bit hb, input logic [1:0] m);
        @(negedge clk);
        cfg_hr_bypass = hb;
        cfg_out_mode  = m;
        core_wdata    = '0;
        core_oe       = '0;
        rst           = 1'b1;
        clear_expect();
        repeat (3) @(negedge clk);
        #1;
        check(dq_rise == '0 && dq_fall == '0, "R1", "dq in reset", -1, {dq_rise, dq_fall}, 0);
        check(!oe_rise && !oe_fall, "R1", "oe in reset", -1, {oe_rise, oe_fall}, 0);
        check(hr_tick == 1'b1, "R1", "hr_tick in reset", -1, hr_tick, 1);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One scenario: random words, checks at every cycle
    task automatic run_mode(input bit hb, input logic [1:0] m);
        string dtag, otag;
        int    g;
        start_mode(hb, m);
        g    = is_reg(m) ? 1 : 0;
        dtag = (m == 2'd0) ? "R4" : ((m == 2'd1) ? "R7" : "R8");
        dtag = {hb ? "R6 " : "R3 ", dtag, " R5"};
        otag = (m == 2'd0) ? "R9" : "R10";
        for (int c = 0; c < NCYC; c++) begin
            logic [LANES-1:0] e_r, e_f;
            logic             o_r, o_f;
            // drive at the negedge of cycle c
            check(hr_tick == ((c % 2) == 0), "R2", "hr_tick", c, hr_tick, (c % 2) == 0);
            if (c == 0)
                check(dq_rise == '0 && !oe_rise, "R1", "first cycle", c, {dq_rise, oe_rise}, 0);
            core_wdata = 16'($urandom);
            core_oe    = 2'($urandom);
            if (hb) begin
                record(c + g, 0);
            end else if (hr_tick) begin
                record(c + 1 + g, 0);
                record(c + 2 + g, 1);
            end
            #1;
            e_r = exp_even[c];
            e_f = (m == 2'd0) ? exp_odd[c] : exp_even[c];
            o_f = exp_oe[c];
            o_r = (m == 2'd0) ? (exp_oe[c] | ((c > 0) ? exp_oe[c-1] : 1'b0)) : exp_oe[c];
            check(dq_rise == e_r, dtag, "dq_rise", c, dq_rise, e_r);
            check(dq_fall == e_f, dtag, "dq_fall", c, dq_fall, e_f);
            check(oe_rise == o_r, otag, "oe_rise", c, oe_rise, o_r);
            check(oe_fall == o_f, otag, "oe_fall", c, oe_fall, o_f);
            check(dq_pin == e_f, "R11", "dq_pin low half", c, dq_pin, e_f);
            check(oe_pin == o_f, "R11", "oe_pin low half", c, oe_pin, o_f);
            @(posedge clk);
            #1;
            if (is_reg(m)) begin
                logic [LANES-1:0] n_r;
                logic             n_o;
                n_r = exp_even[c+1];
                n_o = (m == 2'd0) ? (exp_oe[c+1] | exp_oe[c]) : exp_oe[c+1];
                check(dq_pin == n_r, "R11", "dq_pin high half", c + 1, dq_pin, n_r);
                check(oe_pin == n_o, "R11", "oe_pin high half", c + 1, oe_pin, n_o);
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        rst           = 1'b1;
        cfg_hr_bypass = 1'b0;
        cfg_out_mode  = 2'd0;
        core_wdata    = '0;
        core_oe       = '0;
        run_mode(1'b0, 2'd0);
        run_mode(1'b0, 2'd1);
        run_mode(1'b0, 2'd2);
        run_mode(1'b0, 2'd3);
        run_mode(1'b1, 2'd0);
        run_mode(1'b1, 2'd1);
        run_mode(1'b1, 2'd2);
        finish_run();
    end

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog run did not end, actual timeout expected completion");
        finish_run();
    end

endmodule